// File: doc/BRIEF.md
# Rotating-Priority Bus Arbiter with Retry Masking

This block is the central arbiter of a shared parallel bus with up to a parameterised number of masters. Each master raises its own request line and receives its own grant line. The arbiter watches the bus framing and ready strobes to tell when the bus is idle, and watches the bus lock strobe. It also takes one retry indication per master, which marks a cycle in which that master's transfer was ended with a retry.

Among the requests that are visible, selection rotates: the master granted most recently drops to the lowest priority. A master that was just retried can have its request hidden for a programmed window. This stops a retried master from taking the bus back at once and starving the others. When nobody is asking, the bus either parks on a host master or is left to the arbiter's own agent, which then drives the idle bus itself. A locked transfer either freezes ownership of the whole bus or leaves arbitration untouched, depending on a mode bit. All behaviour is set by an 8-bit control byte written through a simple write strobe.

Top module: `shared_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, `selfDrive` is high, and the control byte is 0.
- R2: In every arbitration cycle the visible request with the lowest index after the most recently granted master, counting with wrap-around, wins. The first arbitration after reset starts its search at master 0.
- R3: The grant changes only in a cycle where the bus is idle (`busFrame` and `busIrdy` both low), where no master holds the grant, or where the owning master has dropped its request. Otherwise the grant is held.
- R4: With mask code 00 in control bits [1:0], retries never hide a request. Bits 7, 5, 3 and 2 of the control byte have no effect.
- R5: Mask codes 01, 10 and 11 hide a master's request for 1x, 2x and 4x `MASK_UNIT` cycles (16, 32 and 64 by default). The window covers the cycles after the retry cycle, and the request is visible again in the cycle after the window. Each master has its own counter, and a new retry restarts that master's window.
- R6: A hidden request is skipped during selection, and other visible requests win instead.
- R7: With the park bit (control bit 4) set, an arbitration cycle with no visible request grants master `HOST_IDX` and drives `selfDrive` low.
- R8: With the park bit clear, an arbitration cycle with no visible request removes every grant and raises `selfDrive`, so the arbiter's own agent drives the idle bus.
- R9: With the bus-wide lock bit (control bit 6) set, `busLock` seen while a master owns the bus freezes the grant on that master. The freeze ends only after a cycle in which `busLock` is low and the bus is idle.
- R10: With the bus-wide lock bit clear, `busLock` has no effect on arbitration.
- R11: A control write takes effect from the cycle after the `ctrlWrEn` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte: [1:0] mask code, [4] park, [6] bus-wide lock |
| busFrame | input | 1 | Bus framing strobe, high while a transfer is active |
| busIrdy | input | 1 | Initiator ready strobe, high while active |
| busLock | input | 1 | Bus lock strobe, high while active |
| req | input | NUM_MASTERS | Request per master |
| retryHit | input | NUM_MASTERS | Retry termination seen for a master in this cycle |
| gnt | output | NUM_MASTERS | Grant per master, at most one high |
| selfDrive | output | 1 | High when no master is granted and the arbiter's agent drives the idle bus |

## Verification
The bench builds the block with its default values: six masters, host index 0 and a mask unit of 16. Rotation therefore wraps across all six request lines, and the 16-, 32- and 64-cycle windows are run through in full, with checks on the last hidden cycle and the first visible cycle of each. The same set-up covers parking on master 0 and both lock modes.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  localparam int CTL_MASK_LSB = 0;
  localparam int CTL_PARK_BIT = 4;
  localparam int CTL_WIDE_BIT = 6;

  typedef struct packed {
    logic       loadGrant;
    logic       parkIdle;
    logic [1:0] maskCode;
  } arbStrobe_t;
endpackage

// File: rtl/arb_datapath.sv
`timescale 1ns/1ps
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int HOST_IDX    = 0,
  parameter int MASK_UNIT   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStrobe_t             strobe,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] retryHit,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic [NUM_MASTERS-1:0] maskVec,
  output logic                   ownerReq,
  output logic                   ownerValid,
  output logic                   selfDrive
);
  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int CW = $clog2(4 * MASK_UNIT + 1);

  logic [CW-1:0] maskLimit;
  always_comb begin
    case (strobe.maskCode)
      2'd1:    maskLimit = CW'(MASK_UNIT);
      2'd2:    maskLimit = CW'(2 * MASK_UNIT);
      2'd3:    maskLimit = CW'(4 * MASK_UNIT);
      default: maskLimit = '0;
    endcase
  end

  // one hide counter per master; restarts on every retry
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mask
    logic [CW-1:0] holdCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   holdCnt <= '0;
      else if (retryHit[m] && maskLimit != '0)     holdCnt <= maskLimit;
      else if (holdCnt != '0)                      holdCnt <= holdCnt - 1'b1;
    end
    assign maskVec[m] = (holdCnt != '0);
  end

  logic [NUM_MASTERS-1:0] visReq;
  assign visReq = req & ~maskVec;

  logic [IW-1:0] lastIdx, ownerIdx, pickIdx;
  logic          pickFound;

  // rotating search starting just after the last winner
  always_comb begin
    int cand;
    pickFound = 1'b0;
    pickIdx   = '0;
    for (int k = 1; k <= NUM_MASTERS; k++) begin
      cand = (int'(lastIdx) + k) % NUM_MASTERS;
      if (!pickFound && visReq[cand]) begin
        pickFound = 1'b1;
        pickIdx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx   <= '0;
      ownerValid <= 1'b0;
      lastIdx    <= IW'(NUM_MASTERS - 1);
    end else if (strobe.loadGrant) begin
      if (pickFound) begin
        ownerIdx   <= pickIdx;
        ownerValid <= 1'b1;
        lastIdx    <= pickIdx;
      end else if (strobe.parkIdle) begin
        ownerIdx   <= IW'(HOST_IDX);
        ownerValid <= 1'b1;
      end else begin
        ownerValid <= 1'b0;
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (ownerValid) gnt[ownerIdx] = 1'b1;
  end

  assign ownerReq  = req[ownerIdx];
  assign selfDrive = ~ownerValid;
endmodule

// File: rtl/arb_control.sv
`timescale 1ns/1ps
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  input  logic       busFrame,
  input  logic       busIrdy,
  input  logic       busLock,
  input  logic       ownerReq,
  input  logic       ownerValid,
  output arbStrobe_t strobe,
  output logic       lockActive
);
  logic [1:0] maskCodeQ;
  logic       parkQ, wideLockQ;
  logic       unusedCtrlBits;
  assign unusedCtrlBits = ^{ctrlWrData[7], ctrlWrData[5], ctrlWrData[3:2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCodeQ <= 2'b00;
      parkQ     <= 1'b0;
      wideLockQ <= 1'b0;
    end else if (ctrlWrEn) begin
      maskCodeQ <= ctrlWrData[CTL_MASK_LSB +: 2];
      parkQ     <= ctrlWrData[CTL_PARK_BIT];
      wideLockQ <= ctrlWrData[CTL_WIDE_BIT];
    end
  end

  logic busIdle, captureLock;
  assign busIdle     = ~busFrame & ~busIrdy;
  assign captureLock = wideLockQ & busLock & ownerValid & ~lockActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  lockActive <= 1'b0;
    else if (captureLock)                       lockActive <= 1'b1;
    else if (lockActive && !busLock && busIdle) lockActive <= 1'b0;
  end

  always_comb begin
    strobe.loadGrant = ~lockActive & ~captureLock &
                       (busIdle | ~ownerValid | ~ownerReq);
    strobe.parkIdle  = parkQ;
    strobe.maskCode  = maskCodeQ;
  end
endmodule

// File: rtl/shared_bus_arbiter.sv
`timescale 1ns/1ps
module shared_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int HOST_IDX    = 0,
  parameter int MASK_UNIT   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctrlWrEn,
  input  logic [7:0]             ctrlWrData,
  input  logic                   busFrame,
  input  logic                   busIrdy,
  input  logic                   busLock,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] retryHit,
  output logic [NUM_MASTERS-1:0] gnt,
  output logic                   selfDrive
);
  arbStrobe_t             strobe;
  logic                   ownerReq, ownerValid, lockActive;
  logic [NUM_MASTERS-1:0] maskVec;

  arb_control i_ctl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .busFrame(busFrame), .busIrdy(busIrdy), .busLock(busLock),
    .ownerReq(ownerReq), .ownerValid(ownerValid),
    .strobe(strobe), .lockActive(lockActive)
  );

  arb_datapath #(
    .NUM_MASTERS(NUM_MASTERS), .HOST_IDX(HOST_IDX), .MASK_UNIT(MASK_UNIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .req(req), .retryHit(retryHit),
    .gnt(gnt), .maskVec(maskVec), .ownerReq(ownerReq),
    .ownerValid(ownerValid), .selfDrive(selfDrive)
  );
endmodule

// File: rtl/arb_checker.sv
`timescale 1ns/1ps
module arb_checker #(
  parameter int NUM_MASTERS = 6,
  parameter int HOST_IDX    = 0
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_MASTERS-1:0] req,
  input logic [NUM_MASTERS-1:0] gnt,
  input logic [NUM_MASTERS-1:0] maskVec,
  input logic                   busFrame,
  input logic                   busIrdy,
  input logic                   lockActive,
  input logic                   parkIdle
);
  localparam logic [NUM_MASTERS-1:0] HOST_ONEHOT = NUM_MASTERS'(1) << HOST_IDX;

  // R3: a requesting owner keeps the bus while a transfer is running
  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((busFrame || busIrdy) && (|(gnt & req))) |=> $stable(gnt));

  // R5: a hidden master is never newly granted
  p_mask_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|maskVec) |=> ((gnt & ~$past(gnt) & $past(maskVec)) == '0));

  // R7: parking hands the idle bus to the host master
  p_park_host_r7: assert property (@(posedge clk) disable iff (!rstN)
    (parkIdle && req == '0 && !busFrame && !busIrdy && !lockActive)
      |=> (gnt == HOST_ONEHOT));

  // R8: without parking the idle bus carries no grant
  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!parkIdle && req == '0 && !busFrame && !busIrdy && !lockActive)
      |=> (gnt == '0));

  // R9: a bus-wide lock freezes ownership
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(gnt));
endmodule

bind shared_bus_arbiter arb_checker #(
  .NUM_MASTERS(NUM_MASTERS), .HOST_IDX(HOST_IDX)
) i_chk (
  .clk(clk), .rstN(rstN), .req(req), .gnt(gnt), .maskVec(maskVec),
  .busFrame(busFrame), .busIrdy(busIrdy), .lockActive(lockActive),
  .parkIdle(strobe.parkIdle)
);

// File: tb/test_shared_bus_arbiter.sv
`timescale 1ns/1ps
module test_shared_bus_arbiter;
  localparam int N = 6;
  localparam int UNIT = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctrlWrEn = 1'b0;
  logic [7:0]   ctrlWrData = '0;
  logic         busFrame = 1'b0, busIrdy = 1'b0, busLock = 1'b0;
  logic [N-1:0] req = '0, retryHit = '0;
  logic [N-1:0] gnt;
  logic         selfDrive;

  int compared = 0;
  int mismatched = 0;

  typedef struct {
    logic         chk;
    logic [N-1:0] g;
    string        tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  shared_bus_arbiter #(.NUM_MASTERS(N), .HOST_IDX(0), .MASK_UNIT(UNIT)) i_shared_bus_arbiter (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .busFrame(busFrame), .busIrdy(busIrdy), .busLock(busLock),
    .req(req), .retryHit(retryHit), .gnt(gnt), .selfDrive(selfDrive)
  );

  // driver: inputs for one cycle plus the grant expected after that edge
  task automatic step(input logic [N-1:0] r, input logic f, input logic i,
                      input logic l, input logic [N-1:0] rt,
                      input logic chk, input logic [N-1:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    req = r; busFrame = f; busIrdy = i; busLock = l; retryHit = rt;
    e.chk = chk; e.g = eg; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic writeCtrl(input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = d;
    req = '0; busFrame = 1'b0; busIrdy = 1'b0; busLock = 1'b0; retryHit = '0;
    e.chk = 1'b0; e.g = '0; e.tag = "write";
    expQ.push_back(e);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        if (e.chk) begin
          compared++;
          if (gnt !== e.g || selfDrive !== (e.g == '0)) begin
            mismatched++;
            $display("FAIL %s: gnt=%b selfDrive=%b expected gnt=%b selfDrive=%b",
                     e.tag, gnt, selfDrive, e.g, (e.g == '0));
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    compared++;
    if (gnt !== '0 || selfDrive !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset: gnt=%b selfDrive=%b expected gnt=000000 selfDrive=1", gnt, selfDrive);
    end

    // R2 rotation, masters 1 and 2 on an idle bus
    step(6'b000110, 0, 0, 0, '0, 1, 6'b000010, "R2 first pick from 0");
    step(6'b000110, 0, 0, 0, '0, 1, 6'b000100, "R2 rotate to 2");
    step(6'b000110, 0, 0, 0, '0, 1, 6'b000010, "R2 wrap to 1");
    step(6'b000000, 0, 0, 0, '0, 1, 6'b000000, "R8 idle no park");
    step(6'b001010, 0, 0, 0, '0, 1, 6'b001000, "R2 pick after 1 is 3");
    // R3 hold while busy
    step(6'b001010, 1, 0, 0, '0, 1, 6'b001000, "R3 busy hold");
    step(6'b000010, 1, 0, 0, '0, 1, 6'b000010, "R3 owner dropped");
    step(6'b001010, 0, 1, 0, '0, 1, 6'b000010, "R3 irdy busy hold");

    // R4 code 00 plus ignored bits 7,5,3,2
    writeCtrl(8'b1010_1100);
    step(6'b000000, 0, 0, 0, '0, 1, 6'b000000, "R4 ignored bits no park");
    step(6'b000100, 0, 0, 0, 6'b000100, 1, 6'b000100, "R4 retry cycle");
    step(6'b000100, 0, 0, 0, '0, 1, 6'b000100, "R4 code 00 not hidden");

    // R5/R6 code 01 with a second requester
    writeCtrl(8'h01);
    step(6'b000100, 0, 0, 0, 6'b000100, 1, 6'b000100, "R5 retry cycle 01");
    for (int j = 1; j <= UNIT; j++)
      step(6'b000110, 0, 0, 0, '0, 1, 6'b000010, "R6 hidden master skipped");
    step(6'b000110, 0, 0, 0, '0, 1, 6'b000100, "R5 visible after 16");

    // R5 codes 10 and 11
    for (int code = 2; code <= 3; code++) begin
      int len;
      len = (code == 2) ? 2 * UNIT : 4 * UNIT;
      writeCtrl(8'(code));
      step(6'b000100, 0, 0, 0, 6'b000100, 1, 6'b000100, "R5 retry cycle");
      for (int j = 1; j <= len; j++)
        step(6'b000100, 0, 0, 0, '0, 1, 6'b000000, "R5 request hidden");
      step(6'b000100, 0, 0, 0, '0, 1, 6'b000100, "R5 request visible again");
    end

    // R7 parking, R11 write latency
    writeCtrl(8'h10);
    step(6'b000000, 0, 0, 0, '0, 1, 6'b000001, "R7 park on host (R11)");
    step(6'b010000, 0, 0, 0, '0, 1, 6'b010000, "R7 request beats park");
    step(6'b000000, 0, 0, 0, '0, 1, 6'b000001, "R7 back to host");

    // R9 bus-wide lock
    writeCtrl(8'h40);
    step(6'b000000, 0, 0, 0, '0, 1, 6'b000000, "R11 park off");
    step(6'b000010, 0, 0, 0, '0, 1, 6'b000010, "R9 owner 1");
    step(6'b001010, 1, 0, 1, '0, 1, 6'b000010, "R9 lock taken");
    step(6'b001000, 0, 0, 1, '0, 1, 6'b000010, "R9 others shut out");
    step(6'b001000, 0, 0, 0, '0, 1, 6'b000010, "R9 release cycle");
    step(6'b001000, 0, 0, 0, '0, 1, 6'b001000, "R9 unlocked");

    // R10 resource lock
    writeCtrl(8'h00);
    step(6'b000010, 0, 0, 0, '0, 1, 6'b000010, "R10 owner 1");
    step(6'b000010, 1, 0, 1, '0, 1, 6'b000010, "R10 locked transfer");
    step(6'b001000, 0, 0, 1, '0, 1, 6'b001000, "R10 lock ignored");

    step(6'b000000, 0, 0, 0, '0, 0, 6'b000000, "flush");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule